// File: doc/BRIEF.md
# Serial NAND Page-Program and Block-Erase Sequencer

This block turns a write request or an erase request into the command frames that a serial NAND flash needs. The frames travel over a byte-wide SPI master port. For a write, the request gives a byte offset and a byte count, and the data arrives on a valid/ready stream. The sequencer cuts the request at 2048-byte page boundaries. For each piece it fills the device cache, sets the write latch and commits the page. For an erase, the request gives a first erase-block index and a count of blocks, and the blocks are erased one after another in ascending order.

Before any device command, the sequencer waits until the device reports that it is no longer busy. After every commit or erase it polls the status register again until the device is idle, then reads the fail bit for that operation. The request ends at the first failure. When the request finishes, the block gives a one-cycle done pulse and holds the number of pages or blocks that completed before any failure. Only one request runs at a time.

Back-pressure on the data stream: a byte moves only in a cycle where both `s_valid` and `s_ready` are high. `s_ready` is high only while a cache-load frame is in its data phase and the SPI port accepts a byte. When `s_valid` is low during that phase, the SPI byte stream stalls. The source must hold `s_valid` and `s_data` until the byte is taken. The SPI port follows the same rule: `spi_valid` and `spi_tx` stay unchanged until `spi_ready` is seen, and `spi_rx` is read in the cycle of the handshake.

Top module: `nand_prog_erase_seq`

## Requirements
- R1: A request is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the done pulse has been given. A request made while busy is ignored. If write and erase are requested together, the write is taken.
- R2: Before the first device command of a request, the block sends status-read frames until bit 0 (busy) of the returned status is clear. A status-read frame is three bytes: 0x0F, then 0xC0, then one byte whose received value is the status.
- R3: A write is split so that each piece covers min(remaining bytes, 2048 − (offset mod 2048)). The pieces go out in ascending address order.
- R4: A cache-load frame is 0x02, then the 16-bit column (offset mod 2048) with the high byte first, then exactly the piece's data bytes, with no dummy byte.
- R5: A one-byte frame 0x06 is sent after every cache load and before its commit, and before every block erase.
- R6: A commit frame is 0x10 followed by the 24-bit row (byte address shifted right by 11), with the most significant byte first.
- R7: An erase frame is 0xD8 followed by the 24-bit row (block index shifted left by 6), with the most significant byte first. Blocks are erased in ascending order.
- R8: After each commit or erase, status is polled until bit 0 is clear. Status bit 3 set after a commit, or bit 2 set after an erase, ends the request with no further command.
- R9: `done` is high for exactly one cycle. `done_count` then holds the number of units completed before any failure, and it keeps that value until the next accepted request.
- R10: The block consumes exactly the requested number of stream bytes, stops at a failure, and sends each consumed byte unchanged as the SPI byte of that same cycle.
- R11: `spi_sel` is high throughout each frame and low for at least one cycle between frames. A byte offered on `spi_valid` keeps its value until `spi_ready` is seen.
- R12: A zero-length request finishes after the initial status wait, with a count of 0 and no program or erase command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_write | input | 1 | Start a write (sampled while idle) |
| req_erase | input | 1 | Start an erase (sampled while idle) |
| req_addr | input | ADDR_W | Byte offset for a write, first block index for an erase |
| req_len | input | LEN_W | Byte count for a write, block count for an erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Pages or blocks completed |
| s_data | input | 8 | Write data byte |
| s_valid | input | 1 | Write data valid |
| s_ready | output | 1 | Write data taken this cycle when valid |
| spi_sel | output | 1 | Device select, high during a frame |
| spi_tx | output | 8 | Byte to send |
| spi_valid | output | 1 | Byte offered to the SPI master |
| spi_ready | input | 1 | SPI master completes the byte this cycle |
| spi_rx | input | 8 | Byte received during the completing transfer |

## Verification
Writes are tried with three patterns. A short write inside one page shows that the column and row are placed correctly. A write that starts 8 bytes before a page end and runs across two more boundaries shows that the split works when a piece is shorter than, equal to, or cut by a page boundary; this test also has data gaps and SPI stalls. A zero-length write shows that the block can finish without touching the array. Erases run over three consecutive blocks, which tests the row shift and the ascending order. Injected program and erase failures at different unit positions show that the count stops where the failure happened and is not simply the requested total. A device that is still busy when a request arrives shows that the initial status wait is honoured. Overlapping and simultaneous requests show the idle-only acceptance and the priority of write over erase.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [2:0] {
    FK_POLL,
    FK_LOAD,
    FK_WREN,
    FK_EXEC,
    FK_ERASE
  } frame_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_DONE
  } state_e;

  localparam logic [7:0] OP_GET_FEAT = 8'h0F;
  localparam logic [7:0] REG_STATUS  = 8'hC0;
  localparam logic [7:0] OP_LOAD     = 8'h02;
  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_EXEC     = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'hD8;

  localparam logic [7:0] MSK_BUSY  = 8'h01;
  localparam logic [7:0] MSK_EFAIL = 8'h04;
  localparam logic [7:0] MSK_PFAIL = 8'h08;

endpackage

// File: rtl/nps_chunk.sv
module nps_chunk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int PAGE_W    = 11,
  parameter int BLK_SHIFT = 6,
  parameter int ROW_W     = 24
) (
  input  logic                is_erase,
  input  logic [ADDR_W-1:0]   pos,
  input  logic [LEN_W-1:0]    rem,
  output logic [15:0]         col,
  output logic [PAGE_W:0]     chunk,
  output logic [ROW_W-1:0]    row,
  output logic [LEN_W-1:0]    step
);
  localparam int CHUNK_W = PAGE_W + 1;
  localparam logic [CHUNK_W-1:0] PAGE_BYTES = CHUNK_W'(1) << PAGE_W;

  logic [PAGE_W-1:0]  col_raw;
  logic [CHUNK_W-1:0] space;

  always_comb begin
    col_raw = pos[PAGE_W-1:0];
    space   = PAGE_BYTES - CHUNK_W'(col_raw);
    col     = 16'(col_raw);
    if (rem < LEN_W'(space)) chunk = rem[CHUNK_W-1:0];
    else                     chunk = space;
    if (is_erase) begin
      row  = ROW_W'(pos << BLK_SHIFT);
      step = LEN_W'(1);
    end else begin
      row  = ROW_W'(pos >> PAGE_W);
      step = LEN_W'(chunk);
    end
  end
endmodule

// File: rtl/nps_frame.sv
module nps_frame
  import nps_pkg::*;
#(
  parameter int PAGE_W    = 11,
  parameter int ROW_BYTES = 3
) (
  input  frame_e                   kind,
  input  logic [PAGE_W+1:0]        idx,
  input  logic [15:0]              col,
  input  logic [8*ROW_BYTES-1:0]   row,
  input  logic [PAGE_W:0]          chunk,
  input  logic [7:0]               data,
  output logic [7:0]               tx,
  output logic                     last,
  output logic                     data_phase
);
  localparam int IDX_W = PAGE_W + 2;

  logic [7:0] row_byte;
  int         sh;

  always_comb begin
    sh       = 8 * (ROW_BYTES - int'(idx));
    row_byte = 8'(row >> sh);
    if (idx == '0 || int'(idx) > ROW_BYTES) row_byte = 8'h00;
  end

  always_comb begin
    tx         = 8'h00;
    last       = 1'b0;
    data_phase = 1'b0;
    unique case (kind)
      FK_POLL: begin
        if (idx == IDX_W'(0))      tx = OP_GET_FEAT;
        else if (idx == IDX_W'(1)) tx = REG_STATUS;
        last = (idx == IDX_W'(2));
      end
      FK_LOAD: begin
        if (idx == IDX_W'(0))      tx = OP_LOAD;
        else if (idx == IDX_W'(1)) tx = col[15:8];
        else if (idx == IDX_W'(2)) tx = col[7:0];
        else begin
          tx         = data;
          data_phase = 1'b1;
        end
        last = (idx == IDX_W'(chunk) + IDX_W'(2));
      end
      FK_WREN: begin
        tx   = OP_WREN;
        last = 1'b1;
      end
      FK_EXEC, FK_ERASE: begin
        if (idx == IDX_W'(0)) tx = (kind == FK_EXEC) ? OP_EXEC : OP_ERASE;
        else                  tx = row_byte;
        last = (idx == IDX_W'(ROW_BYTES));
      end
      default: begin
        tx   = 8'h00;
        last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nand_prog_erase_seq.sv
module nand_prog_erase_seq
  import nps_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 11,
  parameter int BLK_SHIFT = 6,
  parameter int ROW_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_write,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              spi_sel,
  output logic [7:0]        spi_tx,
  output logic              spi_valid,
  input  logic              spi_ready,
  input  logic [7:0]        spi_rx
);
  localparam int IDX_W   = PAGE_W + 2;
  localparam int ROW_W   = 8 * ROW_BYTES;
  localparam int CHUNK_W = PAGE_W + 1;

  state_e            state;
  frame_e            kind, nxt_kind;
  logic              nxt_done;
  logic [IDX_W-1:0]  idx;
  logic              is_erase;
  logic              pre;
  logic [ADDR_W-1:0] pos;
  logic [LEN_W-1:0]  rem;
  logic [CNT_W-1:0]  cnt;

  logic [15:0]        col;
  logic [CHUNK_W-1:0] chunk;
  logic [ROW_W-1:0]   row;
  logic [LEN_W-1:0]   step;
  logic [7:0]         ftx;
  logic               last, data_phase;
  logic               hs, st_busy, fail_bit;
  frame_e             first_kind;

  nps_chunk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
    .BLK_SHIFT(BLK_SHIFT), .ROW_W(ROW_W)
  ) u_chunk (
    .is_erase(is_erase), .pos(pos), .rem(rem),
    .col(col), .chunk(chunk), .row(row), .step(step)
  );

  nps_frame #(
    .PAGE_W(PAGE_W), .ROW_BYTES(ROW_BYTES)
  ) u_frame (
    .kind(kind), .idx(idx), .col(col), .row(row), .chunk(chunk),
    .data(s_data), .tx(ftx), .last(last), .data_phase(data_phase)
  );

  always_comb begin
    spi_sel    = (state == ST_FRAME);
    spi_valid  = spi_sel && (!data_phase || s_valid);
    s_ready    = spi_sel && data_phase && spi_ready;
    spi_tx     = ftx;
    hs         = spi_valid && spi_ready;
    st_busy    = |(spi_rx & MSK_BUSY);
    fail_bit   = is_erase ? |(spi_rx & MSK_EFAIL) : |(spi_rx & MSK_PFAIL);
    first_kind = is_erase ? FK_WREN : FK_LOAD;
    busy       = (state != ST_IDLE);
    done       = (state == ST_DONE);
    done_count = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= FK_POLL;
      nxt_kind <= FK_POLL;
      nxt_done <= 1'b0;
      idx      <= '0;
      is_erase <= 1'b0;
      pre      <= 1'b0;
      pos      <= '0;
      rem      <= '0;
      cnt      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_write || req_erase) begin
            is_erase <= !req_write;
            pos      <= req_addr;
            rem      <= req_len;
            cnt      <= '0;
            pre      <= 1'b1;
            kind     <= FK_POLL;
            idx      <= '0;
            state    <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (hs && !last) begin
            idx <= idx + IDX_W'(1);
          end else if (hs) begin
            idx      <= '0;
            state    <= ST_GAP;
            nxt_done <= 1'b0;
            unique case (kind)
              FK_POLL: begin
                if (st_busy) begin
                  nxt_kind <= FK_POLL;
                end else if (pre) begin
                  pre <= 1'b0;
                  if (rem == '0) nxt_done <= 1'b1;
                  else           nxt_kind <= first_kind;
                end else if (fail_bit) begin
                  nxt_done <= 1'b1;
                end else begin
                  cnt <= cnt + CNT_W'(1);
                  pos <= pos + ADDR_W'(step);
                  rem <= rem - step;
                  if (rem == step) nxt_done <= 1'b1;
                  else             nxt_kind <= first_kind;
                end
              end
              FK_LOAD: nxt_kind <= FK_WREN;
              FK_WREN: nxt_kind <= is_erase ? FK_ERASE : FK_EXEC;
              default: nxt_kind <= FK_POLL;
            endcase
          end
        end
        ST_GAP: begin
          state <= nxt_done ? ST_DONE : ST_FRAME;
          kind  <= nxt_kind;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nps_chk.sv
module nps_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_write,
  input logic             req_erase,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] done_count,
  input logic [7:0]       s_data,
  input logic             s_valid,
  input logic             s_ready,
  input logic             spi_sel,
  input logic [7:0]       spi_tx,
  input logic             spi_valid,
  input logic             spi_ready
);
  // R11
  spi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && !spi_ready) |=> (spi_valid && $stable(spi_tx)));

  // R11
  sel_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid |-> spi_sel);

  // R10
  strm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (spi_valid && spi_ready && spi_tx == s_data));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_write && !req_erase) |=> $stable(done_count));

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_write || req_erase));
endmodule

bind nand_prog_erase_seq nps_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_erase(req_erase),
  .busy(busy), .done(done), .done_count(done_count), .s_data(s_data),
  .s_valid(s_valid), .s_ready(s_ready), .spi_sel(spi_sel), .spi_tx(spi_tx),
  .spi_valid(spi_valid), .spi_ready(spi_ready)
);

// File: tb/nand_prog_erase_seq_bench.sv
`timescale 1ns/100ps
module nand_prog_erase_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_write = 1'b0, req_erase = 1'b0;
  logic [31:0] req_addr = '0;
  logic [23:0] req_len = '0;
  logic        busy, done;
  logic [15:0] done_count;
  logic [7:0]  s_data = 8'h00;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        spi_sel, spi_valid;
  logic [7:0]  spi_tx;
  logic        spi_ready = 1'b1;
  logic [7:0]  spi_rx = 8'h00;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  nand_prog_erase_seq u_nand_prog_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_erase(req_erase),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .done_count(done_count), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .spi_sel(spi_sel), .spi_tx(spi_tx), .spi_valid(spi_valid),
    .spi_ready(spi_ready), .spi_rx(spi_rx)
  );

  // device model state and frame log
  logic [7:0] lg_op[64], lg_b1[64], lg_b2[64], lg_b3[64], lg_df[64], lg_dl[64];
  int         lg_len[64];
  int         lg_n = 0;
  logic [7:0] fb[4];
  logic [7:0] dfirst = 0, dlast = 0;
  int fcount = 0, busy_left = 0, unit_no = 0, fail_unit = -1, wel_err = 0, cyc = 0;
  logic wel = 0, pfail_now = 0, efail_now = 0, stall_en = 0, gap_en = 0;
  int k = 0;
  logic idle_pend = 0;

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 7 + 33) & 255);
  endfunction

  function automatic logic [7:0] stat_byte();
    return {4'b0, pfail_now, efail_now, 1'b0, (busy_left > 0)};
  endfunction

  task automatic end_frame();
    if (lg_n < 64) begin
      lg_op[lg_n] = fb[0]; lg_b1[lg_n] = fb[1]; lg_b2[lg_n] = fb[2]; lg_b3[lg_n] = fb[3];
      lg_len[lg_n] = fcount; lg_df[lg_n] = dfirst; lg_dl[lg_n] = dlast;
      lg_n++;
    end
    case (fb[0])
      8'h06: wel = 1'b1;
      8'h0F: if (busy_left > 0) busy_left--;
      8'h10, 8'hD8: begin
        if (!wel) wel_err++;
        wel = 1'b0;
        pfail_now = (fb[0] == 8'h10) && (unit_no == fail_unit);
        efail_now = (fb[0] == 8'hD8) && (unit_no == fail_unit);
        unit_no++;
        busy_left = 2;
      end
      default: ;
    endcase
  endtask

  initial begin
    for (int i = 0; i < 4; i++) fb[i] = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      spi_ready = !(stall_en && (cyc % 3 == 2));
      spi_rx = (fcount == 2 && fb[0] == 8'h0F) ? stat_byte() : 8'h00;
      #2;
      if (spi_sel && spi_valid && spi_ready) begin
        if (fcount < 4) fb[fcount] = spi_tx;
        if (fcount == 3) dfirst = spi_tx;
        if (fcount >= 3) dlast = spi_tx;
        fcount++;
      end else if (!spi_sel && fcount > 0) begin
        end_frame();
        fcount = 0;
      end
    end
  end

  // write data source
  initial begin
    forever begin
      @(negedge clk);
      if (idle_pend) begin
        s_valid = 1'b0;
        idle_pend = 1'b0;
      end else s_valid = 1'b1;
      s_data = pat(k);
      #2;
      if (s_valid && s_ready) begin
        k++;
        if (gap_en && (k % 4 == 0)) idle_pend = 1'b1;
      end
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fld(input int i, input int w);
    if (i < 0 || i >= lg_n) return -1;
    case (w)
      0: return int'(lg_op[i]);
      1: return int'(lg_b1[i]);
      2: return int'(lg_b2[i]);
      3: return int'(lg_b3[i]);
      4: return lg_len[i];
      5: return int'(lg_df[i]);
      default: return int'(lg_dl[i]);
    endcase
  endfunction

  function automatic int nth_op(input int op, input int nth);
    int c = 0;
    for (int i = 0; i < lg_n; i++)
      if (int'(lg_op[i]) == op) begin
        if (c == nth) return i;
        c++;
      end
    return -1;
  endfunction

  function automatic int count_op(input int op);
    int c = 0;
    for (int i = 0; i < lg_n; i++) if (int'(lg_op[i]) == op) c++;
    return c;
  endfunction

  task automatic clear_env();
    lg_n = 0; unit_no = 0; fail_unit = -1; wel_err = 0; busy_left = 0;
    k = 0; wel = 0; pfail_now = 0; efail_now = 0; stall_en = 0; gap_en = 0;
  endtask

  task automatic issue(input logic w, input logic e, input int addr, input int len);
    @(negedge clk);
    req_write = w; req_erase = e; req_addr = 32'(addr); req_len = 24'(len);
    @(negedge clk);
    req_write = 1'b0; req_erase = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    chk_eq("R9 done seen", int'(done), 1);
    @(negedge clk);
    chk_eq("R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy at reset", int'(busy), 0);
    chk_eq("R11 sel at reset", int'(spi_sel), 0);
    chk_eq("R10 s_ready at reset", int'(s_ready), 0);
    chk_eq("R9 count at reset", int'(done_count), 0);
  endtask

  task automatic t_single_page();
    int li;
    clear_env();
    issue(1, 0, 32'h0002_1100, 10);
    chk_eq("R1 busy after accept", int'(busy), 1);
    wait_done();
    li = nth_op(8'h02, 0);
    chk_eq("R2 first frame status read", fld(0, 0), 8'h0F);
    chk_eq("R2 status register byte", fld(0, 1), 8'hC0);
    chk_eq("R2 status frame length", fld(0, 4), 3);
    chk_eq("R4 load count", count_op(8'h02), 1);
    chk_eq("R4 column high", fld(li, 1), 8'h01);
    chk_eq("R4 column low", fld(li, 2), 8'h00);
    chk_eq("R4 load length", fld(li, 4), 13);
    chk_eq("R4 first data", fld(li, 5), int'(pat(0)));
    chk_eq("R4 last data", fld(li, 6), int'(pat(9)));
    chk_eq("R5 wren after load", fld(li + 1, 0), 8'h06);
    chk_eq("R6 commit op", fld(li + 2, 0), 8'h10);
    chk_eq("R6 row bytes", (fld(li + 2, 1) << 16) | (fld(li + 2, 2) << 8) | fld(li + 2, 3), 32'h42);
    chk_eq("R8 poll after commit", fld(li + 3, 0), 8'h0F);
    chk_eq("R9 count single", int'(done_count), 1);
    chk_eq("R10 bytes consumed", k, 10);
  endtask

  task automatic t_cross_pages();
    int cols[3] = '{2040, 0, 0};
    int lens[3] = '{8, 2048, 12};
    int offs[3] = '{0, 8, 2056};
    int li, ei;
    clear_env();
    stall_en = 1; gap_en = 1;
    issue(1, 0, 3 * 2048 + 2040, 2068);
    wait_done();
    chk_eq("R3 piece count", count_op(8'h02), 3);
    for (int p = 0; p < 3; p++) begin
      li = nth_op(8'h02, p);
      ei = nth_op(8'h10, p);
      chk_eq("R3 piece column", (fld(li, 1) << 8) | fld(li, 2), cols[p]);
      chk_eq("R3 piece length", fld(li, 4) - 3, lens[p]);
      chk_eq("R4 piece first data", fld(li, 5), int'(pat(offs[p])));
      chk_eq("R6 piece row", fld(ei, 3), 3 + p);
    end
    chk_eq("R5 write latch before commits", wel_err, 0);
    chk_eq("R9 count cross", int'(done_count), 3);
    chk_eq("R10 bytes consumed cross", k, 2068);
  endtask

  task automatic t_prebusy();
    clear_env();
    busy_left = 4;
    issue(1, 0, 0, 4);
    wait_done();
    chk_eq("R2 waits out busy", nth_op(8'h02, 0), 5);
    chk_eq("R2 count", int'(done_count), 1);
  endtask

  task automatic t_prog_fail();
    clear_env();
    fail_unit = 1;
    issue(1, 0, 2040, 2064);
    wait_done();
    chk_eq("R8 commits before stop", count_op(8'h10), 2);
    chk_eq("R8 loads before stop", count_op(8'h02), 2);
    chk_eq("R9 count at program fail", int'(done_count), 1);
    chk_eq("R10 bytes at program fail", k, 2056);
  endtask

  task automatic t_erase_run();
    int ei;
    clear_env();
    issue(0, 1, 5, 3);
    wait_done();
    chk_eq("R7 erase count", count_op(8'hD8), 3);
    for (int b = 0; b < 3; b++) begin
      ei = nth_op(8'hD8, b);
      chk_eq("R7 erase row", (fld(ei, 1) << 16) | (fld(ei, 2) << 8) | fld(ei, 3), (5 + b) << 6);
      chk_eq("R5 wren before erase", fld(ei - 1, 0), 8'h06);
    end
    chk_eq("R7 no loads in erase", count_op(8'h02), 0);
    chk_eq("R9 count erase", int'(done_count), 3);
  endtask

  task automatic t_erase_fail();
    int ei;
    clear_env();
    fail_unit = 0;
    issue(0, 1, 32'h3FF, 4);
    wait_done();
    ei = nth_op(8'hD8, 0);
    chk_eq("R8 single erase before stop", count_op(8'hD8), 1);
    chk_eq("R7 high block row", (fld(ei, 1) << 16) | (fld(ei, 2) << 8) | fld(ei, 3), 32'hFFC0);
    chk_eq("R9 count at erase fail", int'(done_count), 0);
  endtask

  task automatic t_zero_len();
    clear_env();
    issue(1, 0, 100, 0);
    wait_done();
    chk_eq("R12 only status frames", count_op(8'h0F), lg_n);
    chk_eq("R12 no commit", count_op(8'h10), 0);
    chk_eq("R12 count zero", int'(done_count), 0);
    chk_eq("R12 no data", k, 0);
  endtask

  task automatic t_busy_ignore();
    clear_env();
    issue(0, 1, 1, 2);
    repeat (3) @(negedge clk);
    chk_eq("R1 busy during erase", int'(busy), 1);
    issue(1, 0, 0, 4);
    wait_done();
    chk_eq("R1 ignored write has no load", count_op(8'h02), 0);
    chk_eq("R1 ignored write no data", k, 0);
    chk_eq("R9 count kept", int'(done_count), 2);
    repeat (10) @(negedge clk);
    chk_eq("R9 count held idle", int'(done_count), 2);
    chk_eq("R1 idle again", int'(busy), 0);
  endtask

  task automatic t_both_req();
    clear_env();
    issue(1, 1, 0, 5);
    wait_done();
    chk_eq("R1 write wins load", count_op(8'h02), 1);
    chk_eq("R1 write wins no erase", count_op(8'hD8), 0);
    chk_eq("R1 write wins count", int'(done_count), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_page();
    t_cross_pages();
    t_prebusy();
    t_prog_fail();
    t_erase_run();
    t_erase_fail();
    t_zero_len();
    t_busy_ignore();
    t_both_req();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule